// File: doc/BRIEF.md
# Flash command interface state machine

This block models the command side of a byte-wide parallel flash memory. A host reaches it through three active-low strobes (chip enable, output enable, write enable), an address bus and a byte data bus, which is split into an input byte, an output byte and an output-drive flag. The strobes are sampled on the block clock. Plain reads return array contents. Any change to the array has to go through a multi-write unlock sequence: byte program, sector erase or full-chip erase.

Program and erase run as timed embedded operations against a small internal array of eight equal sectors. While one is in progress, a read returns a status byte instead of array data. That status byte carries the complement of the expected final bit 7 and a bit 6 that flips after every read, so software can poll until the operation finishes. When the operation ends, the block goes back to read mode without any command. A low-supply input blocks every write cycle while it is asserted.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in read mode. A read of any address returns the stored byte without any command first, and stored bytes survive a reset.
- R2: `dq_oe` is high only while `ce_n`=0, `oe_n`=0 and `we_n`=1. In that case `dq_out` shows the array byte or, during an operation, the status byte.
- R3: With `ce_n`=1, `dq_oe` stays low whatever `oe_n` is. With `ce_n`=0 and `oe_n`=1, `dq_oe` also stays low.
- R4: A write cycle lasts while `ce_n`=0, `we_n`=0 and `oe_n`=1. The address is taken in the first cycle of the write cycle. The data is the `dq_in` value in its last cycle.
- R5: Byte program is four writes: AAh at 555h, 55h at 2AAh, A0h at 555h, then the data at the target address. It then runs for `PROG_CYCLES` clocks and leaves the result in the array.
- R6: Programming can only clear bits. The stored byte becomes the old byte AND the written data.
- R7: Sector erase is the writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h with a sector address. The sector is the top three address bits. Each further 30h written within `SECT_WIN` clocks adds a sector. The erase starts when that window expires and sets every byte of the chosen sectors to FFh, leaving the other sectors unchanged.
- R8: Chip erase is the same five setup writes followed by 10h at 555h. It sets every byte of the array to FFh.
- R9: While the sector window, a program or an erase is in progress, a read returns bit 7 = NOT(expected final bit 7), where the expected bit is the data's bit 7 for a program and 1 for an erase. Bit 6 flips after each completed read, and bits 5..0 are 0. The block returns to read mode by itself at the end.
- R10: A write cycle during which `vdd_low` is high in any cycle is ignored.
- R11: A write of F0h, or any write that does not match the next expected step, returns a pending sequence to read mode. Writes made while an operation is in progress are ignored.
- R12: Raising `ce_n` during an operation does not stop it. The operation completes.
- R13: A write other than 30h inside the sector window abandons the erase. No sector changes, and the block is in read mode at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| vdd_low | input | 1 | Low-supply inhibit; blocks write cycles while high |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data from the host |
| dq_out | output | 8 | Data or status toward the host |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
The bench changes the address and the data in the middle of one write cycle. A design that latched the address late, or the data early, would program the wrong byte or the wrong value. It programs the same byte twice, which exposes any design that overwrites instead of ANDing. It erases two sectors in one window and reads a third, so an erase that hit only one sector, or spilled into a neighbour, shows up as a wrong byte. It also probes status reads during an operation: an inverted or missing bit 7, a bit 6 that does not flip between reads, an F0h accepted mid-operation, a chip enable that aborts the operation, an abandoned window that still erases, and writes that get through under `vdd_low`. Each of these shows as a wrong status byte or a wrong stored byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PSETUP,
    ST_ERA1, ST_ERA2, ST_ERA3, ST_SWIN,
    ST_PBUSY, ST_EBUSY
  } fsm_st_e;

  localparam logic [7:0]  KEY_A     = 8'hAA;
  localparam logic [7:0]  KEY_B     = 8'h55;
  localparam logic [7:0]  OP_PROG   = 8'hA0;
  localparam logic [7:0]  OP_ERASE  = 8'h80;
  localparam logic [7:0]  OP_SECT   = 8'h30;
  localparam logic [7:0]  OP_CHIP   = 8'h10;
  localparam logic [7:0]  OP_RESET  = 8'hF0;
  localparam logic [10:0] KEY_ADR_A = 11'h555;
  localparam logic [10:0] KEY_ADR_B = 11'h2AA;

  // A write matches a sequence step when both the data and the low address bits match
  function automatic logic step_hit(input logic [10:0] a, input logic [7:0] d,
                                    input logic [10:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  // Flash cells can only be cleared by programming
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Status byte returned while an operation is in progress
  function automatic logic [7:0] status_byte(input logic exp7, input logic tog);
    return {~exp7, tog, 6'b0};
  endfunction

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              vdd_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic              rd_active,
  output logic              rd_end,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  logic wr_now, wr_q, rd_q, inh_q;

  assign wr_now    = !ce_n && !we_n && oe_n;
  assign rd_active = !ce_n && !oe_n && we_n;
  assign rd_end    = !rd_active && rd_q;
  // end of a write cycle that saw no low-supply cycle
  assign wr_evt    = !wr_now && wr_q && !inh_q && !vdd_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      inh_q   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_q <= wr_now;
      rd_q <= rd_active;
      if (wr_now && !wr_q) begin
        wr_addr <= addr;
        inh_q   <= vdd_low;
      end else if (wr_now && vdd_low) begin
        inh_q <= 1'b1;
      end
      if (wr_now) wr_data <= dq_in;
    end
  end

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && wr_now) |=> $stable(wr_addr));

endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W  = 11,
  parameter int SECTORS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               prog_commit,
  input  logic [ADDR_W-1:0]  prog_addr,
  input  logic [7:0]         prog_data,
  input  logic               erase_run,
  input  logic [SECTORS-1:0] erase_sel,
  output logic [7:0]         rd_data,
  output logic               erase_last
);
  import flash_cmd_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SEC_W = $clog2(SECTORS);

  logic [7:0]        mem_q [DEPTH];
  logic [ADDR_W-1:0] idx_q;
  logic [SEC_W-1:0]  idx_sec;

  assign idx_sec    = idx_q[ADDR_W-1 -: SEC_W];
  assign erase_last = erase_run && (idx_q == ADDR_W'(DEPTH - 1));
  assign rd_data    = mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx_q <= '0;
    else if (erase_run) idx_q <= idx_q + 1'b1;
    else                idx_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (prog_commit)
      mem_q[prog_addr] <= prog_merge(mem_q[prog_addr], prog_data);
    else if (erase_run && erase_sel[idx_sec])
      mem_q[idx_q] <= 8'hFF;
  end

  assert_prog_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_commit |=> mem_q[$past(prog_addr)] == ($past(mem_q[prog_addr]) & $past(prog_data)));

  assert_erase_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_run && !prog_commit && erase_sel[idx_sec]) |=> mem_q[$past(idx_q)] == 8'hFF);

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W      = 11,
  parameter int SECTORS     = 8,
  parameter int PROG_CYCLES = 16,
  parameter int SECT_WIN    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_evt,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               rd_end,
  input  logic               erase_last,
  input  logic               vdd_low,
  output logic               busy,
  output logic               exp7,
  output logic               tog,
  output logic               prog_commit,
  output logic [ADDR_W-1:0]  prog_addr,
  output logic [7:0]         prog_data,
  output logic               erase_run,
  output logic [SECTORS-1:0] erase_sel
);
  import flash_cmd_pkg::*;

  localparam int SEC_W = $clog2(SECTORS);
  localparam int PCW   = $clog2(PROG_CYCLES + 1);
  localparam int WCW   = $clog2(SECT_WIN + 1);

  fsm_st_e          st;
  logic [PCW-1:0]   pcnt;
  logic [WCW-1:0]   wcnt;
  logic [10:0]      a11;
  logic [SECTORS-1:0] sec_bit;

  assign a11     = wr_addr[10:0];
  assign sec_bit = SECTORS'(1) << wr_addr[ADDR_W-1 -: SEC_W];

  assign busy        = (st == ST_SWIN) || (st == ST_PBUSY) || (st == ST_EBUSY);
  assign exp7        = (st == ST_PBUSY) ? prog_data[7] : 1'b1;
  assign prog_commit = (st == ST_PBUSY) && (pcnt == '0);
  assign erase_run   = (st == ST_EBUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_READ;
      pcnt      <= '0;
      wcnt      <= '0;
      tog       <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      erase_sel <= '0;
    end else begin
      if (busy && rd_end) tog <= ~tog;
      unique case (st)
        ST_READ:  if (wr_evt && step_hit(a11, wr_data, KEY_ADR_A, KEY_A)) st <= ST_UNL1;
        ST_UNL1:  if (wr_evt) st <= step_hit(a11, wr_data, KEY_ADR_B, KEY_B) ? ST_UNL2 : ST_READ;
        ST_UNL2:
          if (wr_evt) begin
            if (step_hit(a11, wr_data, KEY_ADR_A, OP_PROG))       st <= ST_PSETUP;
            else if (step_hit(a11, wr_data, KEY_ADR_A, OP_ERASE)) st <= ST_ERA1;
            else                                                  st <= ST_READ;
          end
        ST_PSETUP:
          if (wr_evt) begin
            if (wr_data == OP_RESET) st <= ST_READ;
            else begin
              prog_addr <= wr_addr;
              prog_data <= wr_data;
              pcnt      <= PCW'(PROG_CYCLES - 1);
              st        <= ST_PBUSY;
            end
          end
        ST_ERA1:  if (wr_evt) st <= step_hit(a11, wr_data, KEY_ADR_A, KEY_A) ? ST_ERA2 : ST_READ;
        ST_ERA2:  if (wr_evt) st <= step_hit(a11, wr_data, KEY_ADR_B, KEY_B) ? ST_ERA3 : ST_READ;
        ST_ERA3:
          if (wr_evt) begin
            if (step_hit(a11, wr_data, KEY_ADR_A, OP_CHIP)) begin
              erase_sel <= '1;
              st        <= ST_EBUSY;
            end else if (wr_data == OP_SECT) begin
              erase_sel <= sec_bit;
              wcnt      <= WCW'(SECT_WIN - 1);
              st        <= ST_SWIN;
            end else st <= ST_READ;
          end
        ST_SWIN:
          if (wr_evt) begin
            if (wr_data == OP_SECT) begin
              erase_sel <= erase_sel | sec_bit;
              wcnt      <= WCW'(SECT_WIN - 1);
            end else begin
              erase_sel <= '0;
              st        <= ST_READ;
            end
          end else if (wcnt == '0) st <= ST_EBUSY;
          else wcnt <= wcnt - 1'b1;
        ST_PBUSY: if (pcnt == '0) st <= ST_READ; else pcnt <= pcnt - 1'b1;
        ST_EBUSY:
          if (erase_last) begin
            erase_sel <= '0;
            st        <= ST_READ;
          end
        default: st <= ST_READ;
      endcase
    end
  end

  assert_inhibit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vdd_low && !busy) |=> $stable(st));

  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_end) |=> (tog != $past(tog)));

  assert_self_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_commit |=> (st == ST_READ));

  assert_erase_runs_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_run && !erase_last) |=> erase_run);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W      = 11,
  parameter int SECTORS     = 8,
  parameter int PROG_CYCLES = 16,
  parameter int SECT_WIN    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              vdd_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  import flash_cmd_pkg::*;

  logic               rd_active, rd_end, wr_evt;
  logic [ADDR_W-1:0]  wr_addr, prog_addr;
  logic [7:0]         wr_data, prog_data, rd_data;
  logic               busy, exp7, tog, prog_commit, erase_run, erase_last;
  logic [SECTORS-1:0] erase_sel;

  flash_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .vdd_low(vdd_low), .addr(addr), .dq_in(dq_in),
    .rd_active(rd_active), .rd_end(rd_end), .wr_evt(wr_evt),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .SECTORS(SECTORS),
                  .PROG_CYCLES(PROG_CYCLES), .SECT_WIN(SECT_WIN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_end(rd_end), .erase_last(erase_last),
    .vdd_low(vdd_low), .busy(busy), .exp7(exp7), .tog(tog),
    .prog_commit(prog_commit), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_run(erase_run), .erase_sel(erase_sel)
  );

  flash_array #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr), .prog_commit(prog_commit),
    .prog_addr(prog_addr), .prog_data(prog_data), .erase_run(erase_run),
    .erase_sel(erase_sel), .rd_data(rd_data), .erase_last(erase_last)
  );

  assign dq_oe  = rd_active;
  assign dq_out = busy ? status_byte(exp7, tog) : rd_data;

  assert_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dq_oe);

  assert_status_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && busy) |-> (dq_out[5:0] == 6'd0));

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;

  localparam int ADDR_W = 11;
  localparam int NVEC   = 50;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_POLL = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vdd_low = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic dq_oe;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .SECTORS(8), .PROG_CYCLES(16), .SECT_WIN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .vdd_low(vdd_low), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // {kind, addr, data, expected, requirement number}
  localparam logic [32:0] VEC [NVEC] = '{
    // R8 chip erase
    {K_WR, 11'h555, 8'hAA, 8'h00, 4'd8}, {K_WR, 11'h2AA, 8'h55, 8'h00, 4'd8},
    {K_WR, 11'h555, 8'h80, 8'h00, 4'd8}, {K_WR, 11'h555, 8'hAA, 8'h00, 4'd8},
    {K_WR, 11'h2AA, 8'h55, 8'h00, 4'd8}, {K_WR, 11'h555, 8'h10, 8'h00, 4'd8},
    {K_POLL, 11'h000, 8'h00, 8'h00, 4'd8},
    {K_RD, 11'h000, 8'h00, 8'hFF, 4'd8}, {K_RD, 11'h7FF, 8'h00, 8'hFF, 4'd8},
    // R5 program 5Ah at 123h
    {K_WR, 11'h555, 8'hAA, 8'h00, 4'd5}, {K_WR, 11'h2AA, 8'h55, 8'h00, 4'd5},
    {K_WR, 11'h555, 8'hA0, 8'h00, 4'd5}, {K_WR, 11'h123, 8'h5A, 8'h00, 4'd5},
    {K_POLL, 11'h123, 8'h00, 8'h00, 4'd5}, {K_RD, 11'h123, 8'h00, 8'h5A, 4'd5},
    // R6 program 0Fh over 5Ah gives 0Ah
    {K_WR, 11'h555, 8'hAA, 8'h00, 4'd6}, {K_WR, 11'h2AA, 8'h55, 8'h00, 4'd6},
    {K_WR, 11'h555, 8'hA0, 8'h00, 4'd6}, {K_WR, 11'h123, 8'h0F, 8'h00, 4'd6},
    {K_POLL, 11'h123, 8'h00, 8'h00, 4'd6}, {K_RD, 11'h123, 8'h00, 8'h0A, 4'd6},
    // R5 program 3Ch at 200h (sector 2)
    {K_WR, 11'h555, 8'hAA, 8'h00, 4'd5}, {K_WR, 11'h2AA, 8'h55, 8'h00, 4'd5},
    {K_WR, 11'h555, 8'hA0, 8'h00, 4'd5}, {K_WR, 11'h200, 8'h3C, 8'h00, 4'd5},
    {K_POLL, 11'h200, 8'h00, 8'h00, 4'd5}, {K_RD, 11'h200, 8'h00, 8'h3C, 4'd5},
    // R5 program 11h at 700h (sector 7)
    {K_WR, 11'h555, 8'hAA, 8'h00, 4'd5}, {K_WR, 11'h2AA, 8'h55, 8'h00, 4'd5},
    {K_WR, 11'h555, 8'hA0, 8'h00, 4'd5}, {K_WR, 11'h700, 8'h11, 8'h00, 4'd5},
    {K_POLL, 11'h700, 8'h00, 8'h00, 4'd5}, {K_RD, 11'h700, 8'h00, 8'h11, 4'd5},
    // R7 erase sectors 1 and 7 in one window; sector 2 untouched
    {K_WR, 11'h555, 8'hAA, 8'h00, 4'd7}, {K_WR, 11'h2AA, 8'h55, 8'h00, 4'd7},
    {K_WR, 11'h555, 8'h80, 8'h00, 4'd7}, {K_WR, 11'h555, 8'hAA, 8'h00, 4'd7},
    {K_WR, 11'h2AA, 8'h55, 8'h00, 4'd7}, {K_WR, 11'h100, 8'h30, 8'h00, 4'd7},
    {K_WR, 11'h700, 8'h30, 8'h00, 4'd7}, {K_POLL, 11'h000, 8'h00, 8'h00, 4'd7},
    {K_RD, 11'h123, 8'h00, 8'hFF, 4'd7}, {K_RD, 11'h700, 8'h00, 8'hFF, 4'd7},
    {K_RD, 11'h200, 8'h00, 8'h3C, 4'd7},
    // R11 F0h breaks the sequence; later writes program nothing
    {K_WR, 11'h555, 8'hAA, 8'h00, 4'd11}, {K_WR, 11'h000, 8'hF0, 8'h00, 4'd11},
    {K_WR, 11'h2AA, 8'h55, 8'h00, 4'd11}, {K_WR, 11'h555, 8'hA0, 8'h00, 4'd11},
    {K_WR, 11'h200, 8'h00, 8'h00, 4'd11}, {K_RD, 11'h200, 8'h00, 8'h3C, 4'd11}
  };

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // write cycle: address a1 and data d1 first, then a2/d2 in the last cycle
  task automatic wr2(input logic [ADDR_W-1:0] a1, input logic [7:0] d1,
                     input logic [ADDR_W-1:0] a2, input logic [7:0] d2);
    @(posedge clk); #1;
    addr = a1; dq_in = d1; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(posedge clk); #1;
    addr = a2; dq_in = d2;
    @(posedge clk); #1;
    we_n = 1'b1; ce_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr2(a, d, a, d);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] v, output logic oe);
    @(posedge clk); #1;
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    v = dq_out; oe = dq_oe;
    @(posedge clk); #1;
    oe_n = 1'b1; ce_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic poll(input logic [ADDR_W-1:0] a, input string req);
    logic [7:0] p, q;
    logic o;
    int n = 0;
    rd(a, p, o);
    rd(a, q, o);
    while (p != q && n < 3000) begin
      p = q;
      rd(a, q, o);
      n++;
    end
    chk(n < 3000, req, q, p);
  endtask

  task automatic unlock;
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    repeat (148000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    logic o;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(dq_oe == 1'b0, "R1 reset state no drive", {7'd0, dq_oe}, 8'h00);

    // R2 / R3 output enable decoding
    #1 ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    chk(dq_oe == 1'b0, "R3 ce_n high", {7'd0, dq_oe}, 8'h00);
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    chk(dq_oe == 1'b0, "R3 oe_n high", {7'd0, dq_oe}, 8'h00);
    oe_n = 1'b0;
    @(negedge clk);
    chk(dq_oe == 1'b1, "R2 read drives", {7'd0, dq_oe}, 8'h01);
    ce_n = 1'b1; oe_n = 1'b1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] k;
      logic [ADDR_W-1:0] a;
      logic [7:0] d, e;
      string tag;
      {k, a, d, e} = VEC[i][32:4];
      tag = $sformatf("R%0d vec %0d", VEC[i][3:0], i);
      case (k)
        K_WR:   wr(a, d);
        K_POLL: poll(a, tag);
        default: begin
          rd(a, v, o);
          chk(v == e && o, tag, v, e);
        end
      endcase
    end

    // R9 status during a program of 80h at 201h
    unlock; wr(11'h555, 8'hA0); wr(11'h201, 8'h80);
    rd(11'h201, v, o);
    rd(11'h201, v2, o);
    chk(v[7] == 1'b0 && v[5:0] == 6'd0, "R9 status bit7 inverted", v, {1'b0, v[6], 6'd0});
    chk(v2[6] != v[6], "R9 bit6 toggles", v2, v ^ 8'h40);
    poll(11'h201, "R9 self return");
    rd(11'h201, v, o);
    chk(v == 8'h80, "R9 program result", v, 8'h80);

    // R12 and R11: erase sector 2, drop ce_n, try F0h mid-operation
    unlock; wr(11'h555, 8'h80); unlock; wr(11'h200, 8'h30);
    repeat (60) @(posedge clk);
    wr(11'h000, 8'hF0);
    rd(11'h200, v, o);
    chk(v[7] == 1'b0 && v[5:0] == 6'd0, "R11 write during erase ignored", v, {1'b0, v[6], 6'd0});
    poll(11'h200, "R12 erase completes");
    rd(11'h200, v, o);
    chk(v == 8'hFF, "R12 erased with ce_n high", v, 8'hFF);

    // R10 writes under low supply
    vdd_low = 1'b1;
    unlock; wr(11'h555, 8'hA0); wr(11'h300, 8'h00);
    vdd_low = 1'b0;
    rd(11'h300, v, o);
    chk(v == 8'hFF, "R10 inhibited program", v, 8'hFF);

    // R4 address from first cycle, data from last cycle
    unlock; wr(11'h555, 8'hA0); wr2(11'h310, 8'hFF, 11'h320, 8'h42);
    poll(11'h310, "R4 program done");
    rd(11'h310, v, o);
    chk(v == 8'h42, "R4 captured addr/data", v, 8'h42);
    rd(11'h320, v, o);
    chk(v == 8'hFF, "R4 late address unused", v, 8'hFF);

    // R13 abandon window
    unlock; wr(11'h555, 8'h80); unlock; wr(11'h300, 8'h30); wr(11'h000, 8'h00);
    rd(11'h310, v, o);
    chk(v == 8'h42, "R13 read mode at once", v, 8'h42);
    repeat (80) @(posedge clk);
    rd(11'h310, v, o);
    chk(v == 8'h42, "R13 sector kept", v, 8'h42);

    // R1 contents survive reset, read with no command
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    rd(11'h310, v, o);
    chk(v == 8'h42 && o, "R1 read after reset", v, 8'h42);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule